// File: doc/BRIEF.md
# Virtual Segment Address Decoder

This block sits at the front of a 32-bit virtual-to-physical address translator. Every access it accepts is sorted into one of four fixed address windows by its upper bits. The two middle windows are never mapped, so the block produces their physical address at once by clearing the top three bits. Accesses to the lower user window and to the top kernel window are handed on to a TLB through a request strobe. The lower window is the exception: while the error-level status bit is set, it maps one to one.

The decoder also catches two kinds of illegal access before any lookup starts. The first is a touch of the top window outside kernel mode. The second is a word access whose two low address bits are not both zero. Either one yields an address-error code that depends on direction: one code for loads and another for stores. The decision logic is combinational. A single register stage sits in front of the outputs, so each accepted request produces its result exactly one clock later.

Top module: `vseg_decode`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` and `out_tlb_req` are 0 and `out_exc_code` is 0.
- R2: `out_valid` equals `in_valid` from one cycle earlier. Whenever `out_valid` is 0, `out_tlb_req` is 0 and `out_exc_code` is 0.
- R3: An access with address bit 31 clear, error-level bit clear and no fault gives `out_tlb_req` = 1 and `out_exc_code` = 0.
- R4: An access with address bit 31 clear and error-level bit set gives `out_tlb_req` = 0, and `out_paddr` equals the virtual address (when there is no fault).
- R5: An access with address bits 31..30 = 2'b10 and no fault gives `out_paddr` = address AND 0x1FFFFFFF and `out_tlb_req` = 0, whatever the status bits are.
- R6: An access with address bits 31..30 = 2'b11 gives `out_tlb_req` = 1 when kernel mode holds and there is no fault. Kernel mode holds when the user bit is 0, or the exception-level bit is 1, or the error-level bit is 1.
- R7: An access with address bits 31..30 = 2'b11 outside kernel mode gives `out_exc_code` = 4 for a read and 5 for a write, with `out_tlb_req` = 0.
- R8: A word access (`in_word` = 1) with address bits 1..0 not equal to 0 gives `out_exc_code` = 4 for a read and 5 for a write, with `out_tlb_req` = 0, in every window. A byte access (`in_word` = 0) is never flagged for alignment.
- R9: `out_tlb_req` and a nonzero `out_exc_code` are never both present. `out_exc_code` takes only the values 0, 4 and 5.
- R10: When `out_tlb_req` is 1, `out_paddr` carries the virtual address unchanged for the TLB to consume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An access is presented this cycle |
| in_vaddr | input | 32 | Virtual address |
| in_write | input | 1 | 1 = store, 0 = load |
| in_word | input | 1 | 1 = word access, 0 = byte access |
| st_user | input | 1 | Status: user-mode bit |
| st_exl | input | 1 | Status: exception-level bit |
| st_erl | input | 1 | Status: error-level bit |
| out_valid | output | 1 | Result of the access accepted one cycle earlier |
| out_paddr | output | 32 | Physical address, or virtual address when a lookup is requested |
| out_tlb_req | output | 1 | The access must go through the TLB |
| out_exc_code | output | 5 | 0 none, 4 load address error, 5 store address error |

## Verification
The hardest case to reach is the top window with the user bit set. Here the result turns on the exception-level and error-level bits, each of which alone restores kernel rights. The stimulus covers the user-bit-set state three times: with neither override, with only the exception-level bit, and with only the error-level bit. It also overlaps misalignment with the privilege fault. Further cases drive the error-level bit on a lower-window address and a misaligned word into an unmapped window. These show that alignment is checked ahead of every mapping choice.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

   typedef enum logic [1:0] {
      SEG_LOW_MAPPED  = 2'd0,
      SEG_DIRECT_A    = 2'd1,
      SEG_DIRECT_B    = 2'd2,
      SEG_HIGH_MAPPED = 2'd3
   } seg_e;

   localparam int EXC_W = 5;
   localparam logic [EXC_W-1:0] EXC_NONE       = 5'd0;
   localparam logic [EXC_W-1:0] EXC_ADDR_LOAD  = 5'd4;
   localparam logic [EXC_W-1:0] EXC_ADDR_STORE = 5'd5;

endpackage

// File: rtl/vseg_classify.sv
module vseg_classify
   import vseg_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  logic              st_user,
   input  logic              st_exl,
   input  logic              st_erl,
   output seg_e              seg,
   output logic              kernel
);

   localparam int TOP = ADDR_W - 1;

   always_comb begin
      if (!vaddr[TOP])          seg = SEG_LOW_MAPPED;
      else if (vaddr[TOP-1])    seg = SEG_HIGH_MAPPED;
      else if (vaddr[TOP-2])    seg = SEG_DIRECT_B;
      else                      seg = SEG_DIRECT_A;
   end

   assign kernel = !st_user || st_exl || st_erl;

endmodule

// File: rtl/vseg_fault.sv
module vseg_fault
   import vseg_pkg::*;
#(
   parameter int ALIGN_W = 2
) (
   input  seg_e               seg,
   input  logic               kernel,
   input  logic [ALIGN_W-1:0] low_bits,
   input  logic               is_word,
   input  logic               is_write,
   output logic               fault,
   output logic [EXC_W-1:0]   exc_code
);

   logic misalign;
   logic priv_bad;

   assign misalign = is_word && (|low_bits);
   assign priv_bad = (seg == SEG_HIGH_MAPPED) && !kernel;
   assign fault    = misalign || priv_bad;

   always_comb begin
      if (!fault)        exc_code = EXC_NONE;
      else if (is_write) exc_code = EXC_ADDR_STORE;
      else               exc_code = EXC_ADDR_LOAD;
   end

endmodule

// File: rtl/vseg_xlate.sv
module vseg_xlate
   import vseg_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int STRIP_W = 3
) (
   input  seg_e              seg,
   input  logic              st_erl,
   input  logic              fault,
   input  logic [ADDR_W-1:0] vaddr,
   output logic [ADDR_W-1:0] paddr,
   output logic              tlb_req
);

   localparam int KEEP_W = ADDR_W - STRIP_W;

   logic [ADDR_W-1:0] keep_mask;

   genvar gi;
   generate
      for (gi = 0; gi < ADDR_W; gi++) begin : g_mask
         assign keep_mask[gi] = (gi < KEEP_W);
      end
   endgenerate

   always_comb begin
      paddr   = vaddr;
      tlb_req = 1'b0;
      unique case (seg)
         SEG_LOW_MAPPED:  tlb_req = !st_erl && !fault;
         SEG_DIRECT_A,
         SEG_DIRECT_B:    paddr = vaddr & keep_mask;
         SEG_HIGH_MAPPED: tlb_req = !fault;
         default:         tlb_req = 1'b0;
      endcase
   end

endmodule

// File: rtl/vseg_decode.sv
module vseg_decode
   import vseg_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int STRIP_W = 3,
   parameter int ALIGN_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       in_vaddr,
   input  logic              in_write,
   input  logic              in_word,
   input  logic              st_user,
   input  logic              st_exl,
   input  logic              st_erl,
   output logic              out_valid,
   output logic [31:0]       out_paddr,
   output logic              out_tlb_req,
   output logic [4:0]        out_exc_code
);

   generate
      if (ADDR_W != 32) begin : g_bad_width
         $error("vseg_decode: ADDR_W must match the 32-bit port width");
      end
      if (STRIP_W < 3 || STRIP_W > ADDR_W - 2) begin : g_bad_strip
         $error("vseg_decode: STRIP_W out of range");
      end
      if (ALIGN_W < 1 || ALIGN_W > 4) begin : g_bad_align
         $error("vseg_decode: ALIGN_W must be 1..4");
      end
   endgenerate

   seg_e              seg;
   logic              kernel;
   logic              fault;
   logic [EXC_W-1:0]  exc_comb;
   logic [ADDR_W-1:0] paddr_comb;
   logic              tlb_comb;

   vseg_classify #(.ADDR_W(ADDR_W)) u_classify (
      .vaddr   (in_vaddr),
      .st_user (st_user),
      .st_exl  (st_exl),
      .st_erl  (st_erl),
      .seg     (seg),
      .kernel  (kernel)
   );

   vseg_fault #(.ALIGN_W(ALIGN_W)) u_fault (
      .seg      (seg),
      .kernel   (kernel),
      .low_bits (in_vaddr[ALIGN_W-1:0]),
      .is_word  (in_word),
      .is_write (in_write),
      .fault    (fault),
      .exc_code (exc_comb)
   );

   vseg_xlate #(.ADDR_W(ADDR_W), .STRIP_W(STRIP_W)) u_xlate (
      .seg     (seg),
      .st_erl  (st_erl),
      .fault   (fault),
      .vaddr   (in_vaddr),
      .paddr   (paddr_comb),
      .tlb_req (tlb_comb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_paddr    <= '0;
         out_tlb_req  <= 1'b0;
         out_exc_code <= EXC_NONE;
      end else begin
         out_valid    <= in_valid;
         out_tlb_req  <= in_valid && tlb_comb;
         out_exc_code <= in_valid ? exc_comb : EXC_NONE;
         if (in_valid) out_paddr <= paddr_comb;
      end
   end

endmodule

// File: rtl/vseg_decode_chk.sv
module vseg_decode_chk #(
   parameter int ADDR_W  = 32,
   parameter int STRIP_W = 3,
   parameter int ALIGN_W = 2
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] in_vaddr,
   input logic        in_write,
   input logic        in_word,
   input logic        st_user,
   input logic        st_exl,
   input logic        st_erl,
   input logic        out_valid,
   input logic [31:0] out_paddr,
   input logic        out_tlb_req,
   input logic [4:0]  out_exc_code
);

   localparam logic [31:0] KEEP = 32'hFFFF_FFFF >> STRIP_W;

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   logic mis;
   logic kern;
   assign mis  = in_word && (|in_vaddr[ALIGN_W-1:0]);
   assign kern = !st_user || st_exl || st_erl;

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (!out_valid && !out_tlb_req && out_exc_code == 5'd0);
      end
   end

   p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      out_valid == $past(in_valid));

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_tlb_req && out_exc_code == 5'd0));

   p_low_lookup_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(in_valid && !in_vaddr[31] && !st_erl && !mis) |-> (out_tlb_req && out_exc_code == 5'd0));

   p_low_flat_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(in_valid && !in_vaddr[31] && st_erl && !mis) |-> (!out_tlb_req && out_paddr == $past(in_vaddr)));

   p_direct_strip_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(in_valid && in_vaddr[31:30] == 2'b10 && !mis) |-> (!out_tlb_req && out_paddr == ($past(in_vaddr) & KEEP)));

   p_high_kernel_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(in_valid && in_vaddr[31:30] == 2'b11 && kern && !mis) |-> out_tlb_req);

   p_high_user_fault_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(in_valid && in_vaddr[31:30] == 2'b11 && !kern) |->
         (!out_tlb_req && out_exc_code == ($past(in_write) ? 5'd5 : 5'd4)));

   p_misalign_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(in_valid && mis) |-> (!out_tlb_req && out_exc_code == ($past(in_write) ? 5'd5 : 5'd4)));

   p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_tlb_req && out_exc_code != 5'd0));

   p_code_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_exc_code == 5'd0 || out_exc_code == 5'd4 || out_exc_code == 5'd5);

   p_lookup_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      out_tlb_req |-> out_paddr == $past(in_vaddr));

endmodule

bind vseg_decode vseg_decode_chk #(
   .ADDR_W(ADDR_W), .STRIP_W(STRIP_W), .ALIGN_W(ALIGN_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vaddr(in_vaddr),
   .in_write(in_write), .in_word(in_word), .st_user(st_user), .st_exl(st_exl),
   .st_erl(st_erl), .out_valid(out_valid), .out_paddr(out_paddr),
   .out_tlb_req(out_tlb_req), .out_exc_code(out_exc_code)
);

// File: tb/vseg_decode_tb.sv
`timescale 1ns/1ps
module vseg_decode_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_vaddr = '0;
   logic        in_write = 1'b0;
   logic        in_word = 1'b0;
   logic        st_user = 1'b0;
   logic        st_exl = 1'b0;
   logic        st_erl = 1'b0;
   logic        out_valid;
   logic [31:0] out_paddr;
   logic        out_tlb_req;
   logic [4:0]  out_exc_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   vseg_decode u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vaddr(in_vaddr),
      .in_write(in_write), .in_word(in_word), .st_user(st_user), .st_exl(st_exl),
      .st_erl(st_erl), .out_valid(out_valid), .out_paddr(out_paddr),
      .out_tlb_req(out_tlb_req), .out_exc_code(out_exc_code)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // present one access, then sample the registered result one edge later
   task automatic access(input string req, input logic [31:0] va, input logic wr, input logic wd,
                         input logic usr, input logic exl, input logic erl,
                         input logic exp_tlb, input logic [4:0] exp_exc,
                         input logic chk_pa, input logic [31:0] exp_pa);
      @(negedge clk);
      in_valid = 1'b1; in_vaddr = va; in_write = wr; in_word = wd;
      st_user = usr; st_exl = exl; st_erl = erl;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, "valid", {31'd0, out_valid}, 32'd1);
      check(req, "tlb_req", {31'd0, out_tlb_req}, {31'd0, exp_tlb});
      check(req, "exc_code", {27'd0, out_exc_code}, {27'd0, exp_exc});
      check("R9", "exclusive", {31'd0, out_tlb_req && out_exc_code != 5'd0}, 32'd0);
      if (chk_pa) check(req, "paddr", out_paddr, exp_pa);
   endtask

   task automatic t_reset;
      check("R1", "valid in reset", {31'd0, out_valid}, 32'd0);
      check("R1", "tlb in reset", {31'd0, out_tlb_req}, 32'd0);
      check("R1", "exc in reset", {27'd0, out_exc_code}, 32'd0);
   endtask

   task automatic t_low_window;
      access("R3", 32'h1234_5678, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd0, 1'b1, 32'h1234_5678);
      access("R10", 32'h0000_1000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 1'b1, 32'h0000_1000);
   endtask

   task automatic t_error_level;
      access("R4", 32'h7FFF_FFFC, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0, 1'b1, 32'h7FFF_FFFC);
      access("R4", 32'h0000_0003, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b1, 32'h0000_0003);
   endtask

   task automatic t_direct;
      access("R5", 32'h8000_1234, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 32'h0000_1234);
      access("R5", 32'hBFFF_FFF0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 32'h1FFF_FFF0);
      access("R5", 32'hA000_0007, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0, 1'b1, 32'h0000_0007);
   endtask

   task automatic t_high_kernel;
      access("R6", 32'hC000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 1'b1, 32'hC000_0000);
      access("R6", 32'hE000_0010, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd0, 1'b0, 32'h0);
      access("R6", 32'hFFFF_FFF8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd0, 1'b0, 32'h0);
   endtask

   task automatic t_high_user;
      access("R7", 32'hC000_1000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd4, 1'b0, 32'h0);
      access("R7", 32'hF000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd5, 1'b0, 32'h0);
      access("R7", 32'hC000_0002, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd5, 1'b0, 32'h0);
   endtask

   task automatic t_misalign;
      access("R8", 32'h0000_0002, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd4, 1'b0, 32'h0);
      access("R8", 32'h8000_0001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd5, 1'b0, 32'h0);
      access("R8", 32'hC000_0003, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd4, 1'b0, 32'h0);
      access("R8", 32'h8000_0003, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 32'h0000_0003);
   endtask

   task automatic t_stream;
      @(negedge clk);
      in_valid = 1'b1; in_vaddr = 32'h8000_0040; in_write = 1'b0; in_word = 1'b1;
      st_user = 1'b0; st_exl = 1'b0; st_erl = 1'b0;
      @(negedge clk);
      check("R2", "first paddr", out_paddr, 32'h0000_0040);
      in_vaddr = 32'hC000_0000; st_user = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R2", "second exc", {27'd0, out_exc_code}, 32'd4);
      check("R2", "second valid", {31'd0, out_valid}, 32'd1);
      in_vaddr = 32'h0000_0004; st_user = 1'b0;
      @(negedge clk);
      check("R2", "idle valid", {31'd0, out_valid}, 32'd0);
      check("R2", "idle tlb", {31'd0, out_tlb_req}, 32'd0);
      check("R2", "idle exc", {27'd0, out_exc_code}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "valid after reset", {31'd0, out_valid}, 32'd0);
      t_low_window;
      t_error_level;
      t_direct;
      t_high_kernel;
      t_high_user;
      t_misalign;
      t_stream;
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule